// File: doc/BRIEF.md
# Auxiliary I/O control register block

This block is a small slave register file for the miscellaneous I/O functions of a workstation. It holds byte-wide configuration, auxiliary, diagnostic and modem-control registers. It also holds a 32-bit system-control register, a 16-bit diagnostic LED register and a write-only power-management location. A register is chosen from the high address bits. The bus is synchronous: writes take effect at the clock edge, and read data arrives one cycle after the read strobe.

The block latches power-fail events from an external level input and produces a level interrupt from them. It also turns certain writes into one-clock request pulses: power-off, system reset and CPU halt. The logic that acts on these requests lives elsewhere. A reset clears only part of the register state, so diagnostic and system-control contents remain visible after a restart.

Top module: `auxio_ctrl`

## Requirements
- R1: With `bus_sel` high, a register is chosen by `addr & 0x0FFF0000`: 0x01800000 config, 0x01900000 aux1, 0x01910000 aux2, 0x01A00000 diag, 0x01B00000 modem control, 0x01F00000 system control, 0x01600000 LED. Address bits outside the mask are ignored.
- R2: The config, aux1, diag and modem-control registers store `wdata[7:0]` and read back zero-extended. Read data appears on `rdata` in the cycle after `rd_en`.
- R3: A write to aux2 stores only `wdata[1:0]` in bits 1:0 and keeps the power-fail status (bit 5). If `wdata[1]` is 1, the status is cleared.
- R4: An aux2 write with `wdata[0]`=1 raises `pwroff_req` for exactly the one cycle after the write.
- R5: A rising edge on `pfail_in` while config bit 3 is 1 sets aux2 bit 5. A falling edge on `pfail_in` clears it.
- R6: `irq` is high exactly while aux2 bit 5 and config bit 3 are both 1.
- R7: A system-control write with `wdata[0]`=1 loads the register with 0x00000002 and pulses `sysrst_req` for one cycle. A system-control write with `wdata[0]`=0 changes nothing.
- R8: Any write with `pm_sel` high pulses `halt_req` for one cycle and stores nothing. A read with `pm_sel` high returns 0.
- R9: Reset clears config, aux1, aux2 and modem control, and drives all pulses and `rdata` low. The diag, system-control and LED registers keep their values through reset.
- R10: The LED register stores `wdata[15:0]` and drives `led_out` directly. The low address bits do not affect its selection.
- R11: `rdata` is 0 after a read of an unmapped offset, after a read with neither select high, and in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Selects the main register window |
| pm_sel | input | 1 | Selects the power-management location |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Byte address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, one cycle after `rd_en` |
| pfail_in | input | 1 | Power-fail level, synchronous to `clk` |
| irq | output | 1 | Power-fail interrupt level |
| pwroff_req | output | 1 | One-cycle power-off request |
| sysrst_req | output | 1 | One-cycle system-reset request |
| halt_req | output | 1 | One-cycle CPU-halt request |
| led_out | output | LEDW | Diagnostic LED drive |

## Verification
The pulse assertions assume that the master never issues two requesting writes to the same location in back-to-back cycles, and that `bus_sel` and `pm_sel` are never high together. The bench tasks idle for at least one cycle after each access and raise only one select at a time. `pfail_in` is taken to be already synchronous to `clk`, and the bench changes it only on the falling clock edge. The diag and system-control registers have no reset, so the bench writes them before it reads them.

// File: rtl/auxio_ctrl.sv
module auxio_ctrl #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int LEDW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            pm_sel,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic            pfail_in,
  output logic            irq,
  output logic            pwroff_req,
  output logic            sysrst_req,
  output logic            halt_req,
  output logic [LEDW-1:0] led_out
);
  localparam logic [AW-1:0] SEL_MASK = AW'('h0FFF0000);
  localparam logic [AW-1:0] OFF_CFG  = AW'('h01800000);
  localparam logic [AW-1:0] OFF_AUX1 = AW'('h01900000);
  localparam logic [AW-1:0] OFF_AUX2 = AW'('h01910000);
  localparam logic [AW-1:0] OFF_DIAG = AW'('h01A00000);
  localparam logic [AW-1:0] OFF_MDM  = AW'('h01B00000);
  localparam logic [AW-1:0] OFF_SYS  = AW'('h01F00000);
  localparam logic [AW-1:0] OFF_LED  = AW'('h01600000);
  localparam int PF_BIT  = 5;
  localparam int IEN_BIT = 3;

  logic [AW-1:0]   off;
  logic            hit_cfg, hit_aux1, hit_aux2, hit_diag, hit_mdm, hit_sys, hit_led;
  logic            wr_aux2, wr_sys;
  logic [7:0]      cfg_q, aux1_q, aux2_q, diag_q, mdm_q;
  logic [7:0]      aux2_d;
  logic [DW-1:0]   sysctrl_q;
  logic [LEDW-1:0] led_q;
  logic            pf_q;
  logic [DW-1:0]   rd_mux;

  assign off      = addr & SEL_MASK;
  assign hit_cfg  = bus_sel && off == OFF_CFG;
  assign hit_aux1 = bus_sel && off == OFF_AUX1;
  assign hit_aux2 = bus_sel && off == OFF_AUX2;
  assign hit_diag = bus_sel && off == OFF_DIAG;
  assign hit_mdm  = bus_sel && off == OFF_MDM;
  assign hit_sys  = bus_sel && off == OFF_SYS;
  assign hit_led  = bus_sel && off == OFF_LED;
  assign wr_aux2  = wr_en && hit_aux2;
  assign wr_sys   = wr_en && hit_sys;

  always_comb begin
    aux2_d = aux2_q;
    if (wr_aux2) begin
      aux2_d = 8'h00;
      aux2_d[1:0]    = wdata[1:0];
      aux2_d[PF_BIT] = aux2_q[PF_BIT] && !wdata[1];
    end
    if (pfail_in && !pf_q && cfg_q[IEN_BIT]) aux2_d[PF_BIT] = 1'b1;
    if (!pfail_in && pf_q)                   aux2_d[PF_BIT] = 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_cfg)  rd_mux = DW'(cfg_q);
    if (hit_aux1) rd_mux = DW'(aux1_q);
    if (hit_aux2) rd_mux = DW'(aux2_q);
    if (hit_diag) rd_mux = DW'(diag_q);
    if (hit_mdm)  rd_mux = DW'(mdm_q);
    if (hit_sys)  rd_mux = sysctrl_q;
    if (hit_led)  rd_mux = DW'(led_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      aux1_q     <= '0;
      aux2_q     <= '0;
      mdm_q      <= '0;
      pf_q       <= 1'b0;
      rdata      <= '0;
      pwroff_req <= 1'b0;
      sysrst_req <= 1'b0;
      halt_req   <= 1'b0;
    end else begin
      if (wr_en && hit_cfg)  cfg_q  <= wdata[7:0];
      if (wr_en && hit_aux1) aux1_q <= wdata[7:0];
      if (wr_en && hit_mdm)  mdm_q  <= wdata[7:0];
      aux2_q     <= aux2_d;
      pf_q       <= pfail_in;
      rdata      <= rd_en ? rd_mux : '0;
      pwroff_req <= wr_aux2 && wdata[0];
      sysrst_req <= wr_sys && wdata[0];
      halt_req   <= wr_en && pm_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && hit_diag) diag_q <= wdata[7:0];
    if (wr_sys && wdata[0]) sysctrl_q <= DW'(2);
    if (wr_en && hit_led)  led_q  <= wdata[LEDW-1:0];
  end

  assign irq     = aux2_q[PF_BIT] && cfg_q[IEN_BIT];
  assign led_out = led_q;
endmodule

// File: rtl/auxio_ctrl_chk.sv
module auxio_ctrl_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          pm_sel,
  input logic          wr_aux2,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] sysctrl_q,
  input logic          pfail_in,
  input logic          irq,
  input logic          pwroff_req,
  input logic          sysrst_req,
  input logic          halt_req
);
  p_pwroff_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pwroff_req |=> !pwroff_req);
  p_sysrst_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sysrst_req |-> sysctrl_q == DW'(2));
  p_halt_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(wr_en && pm_sel));
  p_halt_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> !halt_req);
  p_irq_needs_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(pfail_in));
  p_clear_drops_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_aux2 && wdata[1] && pfail_in == $past(pfail_in)) |=> !irq);
  p_idle_rdata_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rdata == '0);
endmodule

bind auxio_ctrl auxio_ctrl_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .pm_sel(pm_sel),
  .wr_aux2(wr_aux2), .wdata(wdata), .rdata(rdata), .sysctrl_q(sysctrl_q),
  .pfail_in(pfail_in), .irq(irq), .pwroff_req(pwroff_req),
  .sysrst_req(sysrst_req), .halt_req(halt_req)
);

// File: tb/auxio_ctrl_tb_top.sv
module auxio_ctrl_tb_top;
  localparam logic [31:0] A_CFG  = 32'h01800000;
  localparam logic [31:0] A_AUX1 = 32'h01900000;
  localparam logic [31:0] A_AUX2 = 32'h01910000;
  localparam logic [31:0] A_DIAG = 32'h01A00000;
  localparam logic [31:0] A_MDM  = 32'h01B00000;
  localparam logic [31:0] A_SYS  = 32'h01F00000;
  localparam logic [31:0] A_LED  = 32'h01600000;

  logic clk = 0, rst_n = 0, bus_sel = 0, pm_sel = 0, wr_en = 0, rd_en = 0, pfail_in = 0;
  logic [31:0] addr = '0, wdata = '0, rdata;
  logic irq, pwroff_req, sysrst_req, halt_req;
  logic [15:0] led_out;
  logic s_off, s_rst, s_halt;
  logic [31:0] rv;
  int nchk = 0, nfail = 0;
  bit done = 0;

  auxio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .pm_sel(pm_sel), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .pfail_in(pfail_in),
    .irq(irq), .pwroff_req(pwroff_req), .sysrst_req(sysrst_req),
    .halt_req(halt_req), .led_out(led_out)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input bit pm = 0);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1; bus_sel = !pm; pm_sel = pm;
    @(negedge clk);
    s_off = pwroff_req; s_rst = sysrst_req; s_halt = halt_req;
    wr_en = 0; bus_sel = 0; pm_sel = 0;
  endtask

  task automatic rd(input logic [31:0] a, input bit pm = 0, input bit bs = 1);
    @(negedge clk);
    addr = a; rd_en = 1; bus_sel = bs && !pm; pm_sel = pm;
    @(negedge clk);
    rv = rdata;
    rd_en = 0; bus_sel = 0; pm_sel = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset_state();
    check("R9 irq", {31'd0, irq}, 0);
    check("R9 pulses", {29'd0, pwroff_req, sysrst_req, halt_req}, 0);
    check("R9 rdata", rdata, 0);
    rd(A_CFG);  check("R9 cfg", rv, 0);
    rd(A_AUX2); check("R9 aux2", rv, 0);
  endtask

  task automatic t_rw_bytes();
    wr(A_CFG, 32'h123456A5);  rd(A_CFG);  check("R2 cfg", rv, 32'hA5);
    wr(A_AUX1, 32'hFFFFFF3C); rd(A_AUX1); check("R2 aux1", rv, 32'h3C);
    wr(A_DIAG, 32'h0000015A); rd(A_DIAG); check("R2 diag", rv, 32'h5A);
    wr(A_MDM, 32'h00000081);  rd(A_MDM);  check("R2 mdm", rv, 32'h81);
    @(negedge clk); check("R11 idle rdata", rdata, 0);
  endtask

  task automatic t_aux2();
    wr(A_AUX2, 32'hFF); check("R4 pwroff pulse", {31'd0, s_off}, 1);
    @(negedge clk); check("R4 pulse one cycle", {31'd0, pwroff_req}, 0);
    rd(A_AUX2); check("R3 aux2 mask", rv, 32'h03);
    wr(A_AUX2, 32'h00); check("R4 no pulse", {31'd0, s_off}, 0);
    rd(A_AUX2); check("R3 aux2 zero", rv, 0);
  endtask

  task automatic t_pfail_irq();
    wr(A_CFG, 32'h08);
    @(negedge clk); pfail_in = 1;
    @(negedge clk); check("R6 irq set", {31'd0, irq}, 1);
    rd(A_AUX2); check("R5 status set", rv, 32'h20);
    wr(A_CFG, 32'h00); check("R6 irq masked", {31'd0, irq}, 0);
    rd(A_AUX2); check("R5 status kept", rv, 32'h20);
    wr(A_CFG, 32'h08); check("R6 irq unmasked", {31'd0, irq}, 1);
    wr(A_AUX2, 32'h01); check("R4 pulse status", {31'd0, s_off}, 1);
    check("R3 irq kept", {31'd0, irq}, 1);
    rd(A_AUX2); check("R3 status preserved", rv, 32'h21);
    wr(A_AUX2, 32'h02); check("R3 irq cleared", {31'd0, irq}, 0);
    rd(A_AUX2); check("R3 status cleared", rv, 32'h02);
    @(negedge clk); pfail_in = 0;
    wr(A_CFG, 32'h00);
    @(negedge clk); pfail_in = 1;
    @(negedge clk); rd(A_AUX2); check("R5 no set when disabled", rv, 32'h02);
    @(negedge clk); pfail_in = 0;
    wr(A_CFG, 32'h08);
    @(negedge clk); pfail_in = 1;
    @(negedge clk); check("R5 set again", {31'd0, irq}, 1);
    pfail_in = 0;
    @(negedge clk); check("R5 fall clears irq", {31'd0, irq}, 0);
    rd(A_AUX2); check("R5 fall clears status", rv, 32'h02);
  endtask

  task automatic t_sysctrl();
    wr(A_SYS, 32'h1); check("R7 sysrst pulse", {31'd0, s_rst}, 1);
    @(negedge clk); check("R7 pulse one cycle", {31'd0, sysrst_req}, 0);
    rd(A_SYS); check("R7 value", rv, 32'h2);
    wr(A_SYS, 32'hFFFFFFFE); check("R7 no pulse", {31'd0, s_rst}, 0);
    rd(A_SYS); check("R7 unchanged", rv, 32'h2);
  endtask

  task automatic t_pm();
    wr(32'h0, 32'hFF, 1); check("R8 halt pulse", {31'd0, s_halt}, 1);
    @(negedge clk); check("R8 pulse one cycle", {31'd0, halt_req}, 0);
    rd(32'h0, 1); check("R8 read zero", rv, 0);
  endtask

  task automatic t_led();
    wr(A_LED, 32'hBEEF1234); check("R10 led_out", {16'd0, led_out}, 32'h1234);
    rd(A_LED); check("R10 readback", rv, 32'h1234);
    wr(A_LED | 32'h1, 32'h0000CAFE); check("R10 low bit ignored", {16'd0, led_out}, 32'hCAFE);
  endtask

  task automatic t_unmapped();
    rd(32'h01700000); check("R11 unmapped", rv, 0);
    rd(A_AUX1, 0, 0); check("R11 no select", rv, 0);
    rd(32'hF1900000); check("R1 high bits ignored", rv, 32'h3C);
  endtask

  task automatic t_reset_keep();
    wr(A_CFG, 32'h08); wr(A_MDM, 32'h77);
    do_reset();
    rd(A_CFG);  check("R9 cfg cleared", rv, 0);
    rd(A_AUX1); check("R9 aux1 cleared", rv, 0);
    rd(A_AUX2); check("R9 aux2 cleared", rv, 0);
    rd(A_MDM);  check("R9 mdm cleared", rv, 0);
    rd(A_DIAG); check("R9 diag kept", rv, 32'h5A);
    rd(A_SYS);  check("R9 sysctrl kept", rv, 32'h2);
    check("R9 led kept", {16'd0, led_out}, 32'hCAFE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_rw_bytes();
    t_aux2();
    t_pfail_irq();
    t_sysctrl();
    t_pm();
    t_led();
    t_unmapped();
    t_reset_keep();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule